// File: doc/BRIEF.md
# Sync-Locked Scanline Pixel Streamer

This block drives one scanline of 8-bit pixel values onto a parallel output bus, timed against an external composite sync signal. It measures every sync pulse: a line counter restarts on each falling sync edge, the low time is captured on the rising edge, and the line length is read on the next falling edge. It uses these figures to decide whether the line now starting carries active video. If it does, byte transfers are armed for that line.

A fixed number of cycles after the sync edge, a pixel-clock divider starts ticking. Each tick raises a byte request. A serviced request fetches one byte from an external line buffer through a plain combinational read port and drives it onto the output bus. A toggling pixel-clock pin shows the tick rate.

The divider keeps running after the buffer runs out, and stops only at the next sync edge. A request raised while transfers are disarmed stays latched. Software clears it by dropping the request-enable input. If it does not, the next armed line sends its first byte at once.

Top module: `scanline_streamer`

## Requirements
- R1: `sync_in` passes through two synchronizer flops, and a third flop is used for edge detection. A falling edge restarts the line counter at zero. The counter then advances by one per clock and saturates at its maximum.
- R2: At a falling edge the line is classified as active only if all three hold: the low width captured at the last rising edge is below `cfg_short_max`, and the counter value at the edge is not below `cfg_period_min` and not above `cfg_period_max`.
- R3: The falling-edge cycle arms transfers and resets the byte index to 0 when the line is active. Otherwise it disarms them. A disarmed line puts no byte on `pix_out`.
- R4: The tick generator starts when the line counter equals `cfg_start_ofs` and stops on the next falling edge. It ticks once every `cfg_pix_div` clocks, with values below 2 treated as 2. `pix_clk` toggles on each tick.
- R5: A tick with `req_en` high leaves a pending request. While armed, a pending request is serviced in the next cycle. The byte at `buf_addr` (the low 10 bits of the byte index) is registered onto `pix_out` and the index advances by one.
- R6: After `cfg_line_len` bytes, the next serviced request drives `pix_out` to zero and disarms. The generator keeps ticking until the next falling edge.
- R7: A request raised while disarmed stays pending. When a line is armed with a request pending, the first byte appears on `pix_out` two cycles after the falling-edge cycle, before the generator starts.
- R8: Neither the sync edge nor the divider restart clears a pending request. With `req_en` low, pending requests are cleared and ticks leave none.
- R9: `cfg_line_len` ranges from 1 to 1024 bytes, and 0 behaves as 1.
- R10: After reset, `pix_out`, `pix_clk` and `buf_addr` are zero and transfers are disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Composite sync, asynchronous |
| req_en | input | 1 | Byte request enable; low clears a pending request |
| cfg_short_max | input | 16 | Low widths below this count as normal line sync |
| cfg_period_min | input | 16 | Shortest accepted line length, clocks |
| cfg_period_max | input | 16 | Longest accepted line length, clocks |
| cfg_start_ofs | input | 16 | Line count at which the pixel divider starts |
| cfg_pix_div | input | 16 | Pixel period in clocks (minimum 2) |
| cfg_line_len | input | 11 | Bytes per line, 1 to 1024 |
| buf_data | input | 8 | Line buffer read data for `buf_addr` |
| buf_addr | output | 10 | Line buffer read address |
| pix_out | output | 8 | Parallel pixel bus |
| pix_clk | output | 1 | Pixel clock, toggles per tick |

## Verification
The assertions run on every cycle and cover the local invariants. The counter restarts after a sync edge. Ticks are never adjacent. The generator is stopped after an edge. Dropping `req_en` empties the pending request. The bus moves only when an armed request is serviced, and the byte index stays inside the line. Other behaviours need whole lines of stimulus and are shown only by the bench's scenarios against its reference model. These are the classification of wide-sync and short-period lines, the early byte caused by a stale request, its removal by toggling `req_en`, and the single-byte and 1024-byte line lengths.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_SEND = 2'd1,
    XF_TAIL = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic din,
  output logic fall,
  output logic rise
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
  assign rise = ~sh_q[STAGES] & sh_q[STAGES-1];
endmodule

// File: rtl/line_timer.sv
module line_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             fall,
  input  logic             rise,
  input  logic [CNT_W-1:0] cfg_short_max,
  input  logic [CNT_W-1:0] cfg_period_min,
  input  logic [CNT_W-1:0] cfg_period_max,
  input  logic [CNT_W-1:0] cfg_start_ofs,
  output logic             arm,
  output logic             start_hit
);
  logic [CNT_W-1:0] lcnt_q, lcnt_d;
  logic [CNT_W-1:0] width_q, width_d;
  logic             width_en;
  logic             line_ok;

  // line counter: restart on falling sync edge, saturate otherwise
  always_comb begin
    if (fall)         lcnt_d = '0;
    else if (&lcnt_q) lcnt_d = lcnt_q;
    else              lcnt_d = lcnt_q + 1'b1;
  end

  // low width captured on the rising edge
  assign width_en = rise;
  always_comb begin
    width_d = width_q;
    if (width_en) width_d = lcnt_q;
  end

  // period is the counter value seen in the falling-edge cycle
  always_comb begin
    line_ok = (width_q < cfg_short_max) &&
              (lcnt_q >= cfg_period_min) &&
              (lcnt_q <= cfg_period_max);
  end

  assign arm       = fall & line_ok;
  assign start_hit = (lcnt_q == cfg_start_ofs);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lcnt_q  <= '0;
      width_q <= '0;
    end else begin
      lcnt_q  <= lcnt_d;
      width_q <= width_d;
    end
  end

  assert_cnt_restart_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    fall |=> (lcnt_q == '0));
endmodule

// File: rtl/pixel_tick.sv
module pixel_tick #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             fall,
  input  logic             start_hit,
  input  logic [CNT_W-1:0] cfg_pix_div,
  output logic             tick,
  output logic             pix_clk
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] dcnt_q, dcnt_d;
  logic             pclk_q, pclk_d;
  logic [CNT_W-1:0] div_last;
  logic             wrap;

  // divider values below 2 are clamped to 2
  assign div_last = (cfg_pix_div < CNT_W'(2)) ? CNT_W'(1) : (cfg_pix_div - 1'b1);
  assign wrap     = (dcnt_q == div_last);
  assign tick     = run_q & ~fall & wrap;

  always_comb begin
    run_d = run_q;
    if (fall)           run_d = 1'b0;
    else if (start_hit) run_d = 1'b1;
  end

  always_comb begin
    if (fall || !run_q || wrap) dcnt_d = '0;
    else                        dcnt_d = dcnt_q + 1'b1;
  end

  always_comb begin
    pclk_d = pclk_q ^ tick;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      dcnt_q <= '0;
      pclk_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      dcnt_q <= dcnt_d;
      pclk_q <= pclk_d;
    end
  end

  assign pix_clk = pclk_q;

  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    tick |=> !tick);
  assert_stop_on_sync_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    fall |=> !run_q);
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import scan_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int DATA_W = 8,
  localparam int ADDR_W = LEN_W - 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              fall,
  input  logic              arm,
  input  logic              tick,
  input  logic              req_en,
  input  logic [LEN_W-1:0]  cfg_line_len,
  input  logic [DATA_W-1:0] buf_data,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] pix_out
);
  xfer_state_e       state_q, state_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  idx_inc;
  logic              svc;

  assign len_eff = (cfg_line_len == '0) ? LEN_W'(1) : cfg_line_len;
  assign idx_inc = idx_q + 1'b1;
  assign svc     = pend_q & (state_q != XF_IDLE) & ~fall;

  // request latch: cleared only through req_en, never by the sync edge
  always_comb begin
    pend_d = pend_q;
    if (!req_en)  pend_d = 1'b0;
    else if (tick) pend_d = 1'b1;
    else if (svc)  pend_d = 1'b0;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    out_d   = out_q;
    if (fall) begin
      state_d = arm ? XF_SEND : XF_IDLE;
      idx_d   = '0;
    end else if (svc) begin
      unique case (state_q)
        XF_SEND: begin
          out_d = buf_data;
          idx_d = idx_inc;
          if (idx_inc == len_eff) state_d = XF_TAIL;
        end
        XF_TAIL: begin
          out_d   = '0;
          state_d = XF_IDLE;
        end
        default: state_d = XF_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XF_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pend_q  <= pend_d;
      out_q   <= out_d;
    end
  end

  assign buf_addr = idx_q[ADDR_W-1:0];
  assign pix_out  = out_q;

  assert_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_en |=> !pend_q);
  assert_bus_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!pend_q || state_q == XF_IDLE || fall) |=> $stable(pix_out));
  assert_index_in_line_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == XF_SEND) |-> (idx_q < len_eff));
endmodule

// File: rtl/scanline_streamer.sv
module scanline_streamer #(
  parameter int CNT_W       = 16,
  parameter int LEN_W       = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = LEN_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              req_en,
  input  logic [CNT_W-1:0]  cfg_short_max,
  input  logic [CNT_W-1:0]  cfg_period_min,
  input  logic [CNT_W-1:0]  cfg_period_max,
  input  logic [CNT_W-1:0]  cfg_start_ofs,
  input  logic [CNT_W-1:0]  cfg_pix_div,
  input  logic [LEN_W-1:0]  cfg_line_len,
  input  logic [DATA_W-1:0] buf_data,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] pix_out,
  output logic              pix_clk
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       fall, rise, arm, start_hit, tick;

  // asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .din(sync_in), .fall(fall), .rise(rise)
  );

  line_timer #(.CNT_W(CNT_W)) u_line (
    .clk(clk), .rst_ni(rst_ni), .fall(fall), .rise(rise),
    .cfg_short_max(cfg_short_max), .cfg_period_min(cfg_period_min),
    .cfg_period_max(cfg_period_max), .cfg_start_ofs(cfg_start_ofs),
    .arm(arm), .start_hit(start_hit)
  );

  pixel_tick #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_ni(rst_ni), .fall(fall), .start_hit(start_hit),
    .cfg_pix_div(cfg_pix_div), .tick(tick), .pix_clk(pix_clk)
  );

  xfer_engine #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_ni(rst_ni), .fall(fall), .arm(arm), .tick(tick),
    .req_en(req_en), .cfg_line_len(cfg_line_len), .buf_data(buf_data),
    .buf_addr(buf_addr), .pix_out(pix_out)
  );
endmodule

// File: tb/scanline_streamer_tb.sv
module scanline_streamer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b1;
  logic        req_en = 1'b1;
  logic [15:0] cfg_short_max = 16'd20;
  logic [15:0] cfg_period_min = 16'd200;
  logic [15:0] cfg_period_max = 16'd400;
  logic [15:0] cfg_start_ofs = 16'd40;
  logic [15:0] cfg_pix_div = 16'd3;
  logic [10:0] cfg_line_len = 11'd8;
  logic [7:0]  buf_data;
  logic [9:0]  buf_addr;
  logic [7:0]  pix_out;
  logic        pix_clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  function automatic int bufv(int a);
    return (a * 37 + 11) & 255;
  endfunction

  assign buf_data = 8'(bufv(int'(buf_addr)));

  scanline_streamer u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .req_en(req_en),
    .cfg_short_max(cfg_short_max), .cfg_period_min(cfg_period_min),
    .cfg_period_max(cfg_period_max), .cfg_start_ofs(cfg_start_ofs),
    .cfg_pix_div(cfg_pix_div), .cfg_line_len(cfg_line_len),
    .buf_data(buf_data), .buf_addr(buf_addr), .pix_out(pix_out), .pix_clk(pix_clk)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every clock
  int m_rs1, m_rs2, m_s1, m_s2, m_s3;
  int m_lcnt, m_width, m_run, m_dcnt, m_pclk, m_pend, m_st, m_idx, m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
      m_lcnt = 0; m_width = 0; m_run = 0; m_dcnt = 0; m_pclk = 0;
      m_pend = 0; m_st = 0; m_idx = 0; m_out = 0;
    end else if (m_rs2 == 0) begin
      m_rs2 = m_rs1; m_rs1 = 1;
    end else begin
      int fall, rise, dv, ln, tick, act, svc, old_lcnt, old_run;
      fall = (m_s3 == 1 && m_s2 == 0);
      rise = (m_s3 == 0 && m_s2 == 1);
      dv   = (cfg_pix_div < 2) ? 2 : int'(cfg_pix_div);
      ln   = (cfg_line_len == 0) ? 1 : int'(cfg_line_len);
      tick = (m_run == 1 && !fall && m_dcnt == dv - 1);
      act  = fall && (m_width < int'(cfg_short_max)) &&
             (m_lcnt >= int'(cfg_period_min)) && (m_lcnt <= int'(cfg_period_max));
      svc  = (m_pend == 1 && m_st != 0 && !fall);
      old_lcnt = m_lcnt; old_run = m_run;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(sync_in);
      if (rise) m_width = old_lcnt;
      if (fall) m_lcnt = 0; else if (old_lcnt < 65535) m_lcnt = old_lcnt + 1;
      if (fall) m_run = 0; else if (old_lcnt == int'(cfg_start_ofs)) m_run = 1;
      if (fall || old_run == 0 || m_dcnt == dv - 1) m_dcnt = 0; else m_dcnt = m_dcnt + 1;
      if (tick) m_pclk = 1 - m_pclk;
      if (!req_en) m_pend = 0; else if (tick) m_pend = 1; else if (svc) m_pend = 0;
      if (fall) begin
        m_st = act ? 1 : 0; m_idx = 0;
      end else if (svc) begin
        if (m_st == 1) begin
          m_out = bufv(m_idx & 1023); m_idx = m_idx + 1;
          if (m_idx == ln) m_st = 2;
        end else begin
          m_out = 0; m_st = 0;
        end
      end
    end
  end

  // per-cycle comparison and line statistics
  int ln_nz, ln_tog, ln_maxa;
  logic prev_pclk = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(pix_out) == m_out, "R5 R6 R7 pix_out", int'(pix_out), m_out);
      check(int'(pix_clk) == m_pclk, "R4 pix_clk", int'(pix_clk), m_pclk);
      check(int'(buf_addr) == (m_idx & 1023), "R5 R9 buf_addr", int'(buf_addr), m_idx & 1023);
      if (pix_out != 0) ln_nz++;
      if (pix_clk != prev_pclk) ln_tog++;
      if (int'(buf_addr) > ln_maxa) ln_maxa = int'(buf_addr);
      prev_pclk = pix_clk;
    end
  end

  // probe: 0 none, 1 bus must be zero, 2 first byte must already be out
  task automatic run_line(int w, int p, bit clean, int probe);
    @(negedge clk);
    sync_in = 1'b0;
    if (clean) req_en = 1'b0;
    ln_nz = 0; ln_tog = 0; ln_maxa = 0;
    for (int c = 1; c < p; c++) begin
      @(negedge clk);
      if (c == 3 && clean) req_en = 1'b1;
      if (c == 4 && probe == 1)
        check(pix_out == 8'd0, "R8 R1 cleared request, no early byte", int'(pix_out), 0);
      if (c == 4 && probe == 2)
        check(int'(pix_out) == bufv(0), "R7 R1 stale request sends byte at once", int'(pix_out), bufv(0));
      if (c == w) sync_in = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pix_out == 8'd0, "R10 reset pix_out", int'(pix_out), 0);
    check(pix_clk == 1'b0, "R10 reset pix_clk", int'(pix_clk), 0);
    check(buf_addr == 10'd0, "R10 reset buf_addr", int'(buf_addr), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_line(10, 300, 1, 0);            // first edge after reset: too short
    run_line(10, 300, 1, 1);            // active, clean arm
    run_line(10, 300, 1, 1);
    check(ln_maxa == 8, "R5 eight bytes addressed", ln_maxa, 8);
    check(ln_tog > 16, "R6 divider runs past last byte", ln_tog, 17);
    run_line(10, 300, 0, 2);            // armed with stale request
    run_line(30, 300, 1, 1);            // wide sync pulse
    run_line(10, 300, 1, 0);            // classified from wide pulse
    check(ln_nz == 0, "R2 R3 wide sync line emits nothing", ln_nz, 0);
    run_line(10, 150, 1, 0);            // short period
    run_line(10, 300, 1, 0);
    check(ln_nz == 0, "R2 R3 short period line emits nothing", ln_nz, 0);
    run_line(10, 300, 1, 1);
    check(ln_nz > 0, "R3 active line emits bytes", ln_nz, 1);

    cfg_pix_div = 16'd1; cfg_line_len = 11'd1;   // clamp to 2, single byte
    run_line(10, 300, 1, 1);
    run_line(10, 300, 1, 1);
    check(ln_maxa == 1, "R9 R4 single byte line", ln_maxa, 1);
    check(ln_tog > 100, "R4 divider clamped to two", ln_tog, 101);

    cfg_pix_div = 16'd2; cfg_line_len = 11'd1024; cfg_period_max = 16'd3000;
    run_line(10, 2500, 1, 1);
    check(ln_maxa == 1023, "R9 full 1024 byte line", ln_maxa, 1023);
    run_line(10, 300, 1, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule